// File: doc/BRIEF.md
# Capture/Compare 8-bit Timer

This block is an 8-bit free-running timer peripheral with a small register bus. A fixed prescaler divides the system clock, and the counter advances once per prescaler period, wrapping from FFh to 00h. Two capture channels latch the counter on a selectable edge of their input pins. Two compare channels drive output pins to a programmed level when the counter reaches their reference value. Three event groups (capture, compare, overflow) each have an enable, and they are combined into one interrupt line.

Software programs the block through nine byte-wide locations at word addresses 0 to 8. Software can also force either compare pin to its programmed level without a match. When a one-pulse or PWM mode select is set, the second output-level bit becomes the level source for compare pin 1. Status flags are sticky and are cleared by writing 1 to them. Read data is registered and appears one clock after the address.

Address map: 0 control A, 1 control B, 2 status, 3 capture 1, 4 capture 2, 5 compare 1, 6 compare 2, 7 counter, 8 alternate counter.

Top module: `cct_timer8`

## Requirements
- R1: After reset, control A, control B, status, both capture registers and both compare registers read 00h, both compare pins are 0 and `irq` is 0.
- R2: The counter advances by one every PRESCALE clocks and wraps FFh to 00h. On the wrap, status bit 4 (overflow) sets. Address 7 and address 8 both return the count, and reading either does not clear the overflow flag.
- R3: Writing status (address 2) clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged. Status bits are: 0 capture 1, 1 capture 2, 2 compare 1, 3 compare 2, 4 overflow.
- R4: A capture input passes through a two-flop synchronizer before edge detection. On the selected edge, the current count is latched into that capture register and its status flag sets. The edge select is control A bit 1 for channel 1 and control B bit 4 for channel 2 (0 selects falling, 1 selects rising). The other edge changes neither the register nor the flag.
- R5: When the counter takes the value of compare register N, status flag for channel N sets. When that channel's output enable is set (control B bit 0 for channel 1, bit 1 for channel 2), the channel's output level is copied to compare pin N: control A bit 0 for pin 1, bit 2 for pin 2.
- R6: Writing control A with bit 3 (pin 1) or bit 4 (pin 2) set copies the written output level to that pin at once if its output enable is set. With the bit written 0, or with the enable clear, the pin is unchanged.
- R7: When control B bit 2 (one-pulse) or bit 3 (PWM) is set, control A bit 2 is the level copied to compare pin 1, on both a match and a force.
- R8: One clock after the flags or enables change, `irq` equals (A bit 7 AND (flag 0 OR flag 1)) OR (A bit 6 AND (flag 2 OR flag 3)) OR (A bit 5 AND flag 4).
- R9: A compare pin holds its value between updates. It never changes while its output enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, one clock after the address |
| cap1_in | input | 1 | Capture channel 1 pin (asynchronous) |
| cap2_in | input | 1 | Capture channel 2 pin (asynchronous) |
| cmp1_out | output | 1 | Compare channel 1 pin |
| cmp2_out | output | 1 | Compare channel 2 pin |
| irq | output | 1 | Combined interrupt request |

## Verification
Every cycle, the assertions check several rules. The counter never moves by anything but a single step. A wrap always leaves the overflow flag set. A capture value never changes without its flag. The interrupt stays low when all enables are off. A compare pin is frozen while its enable is clear. The bench scenarios show the rest: the captured value lies between the counts read before and after the edge, a match lands on the programmed count, force and mode routing pick the right level, and the interrupt is swept over every combination of the three enables for several flag states.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 4;
  localparam int NCH    = 2;
  localparam int NFLAG  = 5;

  localparam logic [ADDR_W-1:0] A_CTLA = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTLB = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] A_CAP1 = 4'd3;
  localparam logic [ADDR_W-1:0] A_CAP2 = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMP1 = 4'd5;
  localparam logic [ADDR_W-1:0] A_CMP2 = 4'd6;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd7;
  localparam logic [ADDR_W-1:0] A_ALT  = 4'd8;

  // control A field positions
  localparam int CA_CAPIE = 7;
  localparam int CA_CMPIE = 6;
  localparam int CA_OVFIE = 5;
  localparam int CA_FRC2  = 4;
  localparam int CA_FRC1  = 3;
  localparam int CA_LVL2  = 2;
  localparam int CA_EDG1  = 1;
  localparam int CA_LVL1  = 0;

  // control B field positions
  localparam int CB_OE1   = 0;
  localparam int CB_OE2   = 1;
  localparam int CB_OPM   = 2;
  localparam int CB_PWM   = 3;
  localparam int CB_EDG2  = 4;
  localparam int CB_W     = 5;

  // status field positions
  localparam int ST_CAP1 = 0;
  localparam int ST_CAP2 = 1;
  localparam int ST_CMP1 = 2;
  localparam int ST_CMP2 = 3;
  localparam int ST_OVF  = 4;
endpackage

// File: rtl/cct_count.sv
module cct_count #(
  parameter int W   = 8,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         step,
  output logic         wrap
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre;
  logic          last;

  assign last    = (pre == PW'(DIV - 1));
  assign step    = last;
  assign cnt_nxt = cnt + 1'b1;
  assign wrap    = last && (cnt == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= last ? '0 : pre + 1'b1;
      if (last) cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pin,
  input  logic         rise_sel,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] val,
  output logic         hit
);
  logic [2:0] sh;
  logic       rise, fall;

  assign rise = sh[1] & ~sh[2];
  assign fall = ~sh[1] & sh[2];
  assign hit  = rise_sel ? rise : fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      val <= '0;
    end else begin
      sh <= {sh[1:0], pin};
      if (hit) val <= cnt;
    end
  end
endmodule

// File: rtl/cct_compare.sv
module cct_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] ref_val,
  input  logic         oe,
  input  logic         lvl,
  input  logic         force_go,
  input  logic         force_lvl,
  output logic         pin,
  output logic         match
);
  assign match = step && (cnt_nxt == ref_val);

  always_ff @(posedge clk) begin
    if (rst)                  pin <= 1'b0;
    else if (force_go && oe)  pin <= force_lvl;
    else if (match && oe)     pin <= lvl;
  end
endmodule

// File: rtl/cct_timer8.sv
module cct_timer8
  import cct_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              cap1_in,
  input  logic              cap2_in,
  output logic              cmp1_out,
  output logic              cmp2_out,
  output logic              irq
);
  logic [REG_W-1:0] ctl_a_q;
  logic [CB_W-1:0]  ctl_b_q;
  logic [NFLAG-1:0] stat_q;
  logic [REG_W-1:0] cmp_q   [NCH];
  logic [REG_W-1:0] cap_val [NCH];
  logic [NCH-1:0]   cap_hit, cmp_hit, cmp_pin, cap_pin, edge_sel;
  logic [NCH-1:0]   oe, lvl, frc_go, frc_lvl;
  logic [REG_W-1:0] cnt, cnt_nxt;
  logic             step, wrap, alt_mode;
  logic             wr_a, wr_stat;
  logic [NFLAG-1:0] set_v, clr_v;

  assign wr_a     = bus_we && (bus_addr == A_CTLA);
  assign wr_stat  = bus_we && (bus_addr == A_STAT);
  assign alt_mode = ctl_b_q[CB_OPM] | ctl_b_q[CB_PWM];

  assign cap_pin  = {cap2_in, cap1_in};
  assign edge_sel = {ctl_b_q[CB_EDG2], ctl_a_q[CA_EDG1]};
  assign oe       = {ctl_b_q[CB_OE2], ctl_b_q[CB_OE1]};
  assign lvl      = {ctl_a_q[CA_LVL2],
                     alt_mode ? ctl_a_q[CA_LVL2] : ctl_a_q[CA_LVL1]};
  assign frc_go   = {wr_a && bus_wdata[CA_FRC2], wr_a && bus_wdata[CA_FRC1]};
  assign frc_lvl  = {bus_wdata[CA_LVL2],
                     alt_mode ? bus_wdata[CA_LVL2] : bus_wdata[CA_LVL1]};

  cct_count #(.W(REG_W), .DIV(PRESCALE)) u_count (
    .clk(clk), .rst(rst), .cnt(cnt), .cnt_nxt(cnt_nxt),
    .step(step), .wrap(wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cct_capture #(.W(REG_W)) u_cap (
      .clk(clk), .rst(rst), .pin(cap_pin[i]), .rise_sel(edge_sel[i]),
      .cnt(cnt), .val(cap_val[i]), .hit(cap_hit[i])
    );
    cct_compare #(.W(REG_W)) u_cmp (
      .clk(clk), .rst(rst), .step(step), .cnt_nxt(cnt_nxt),
      .ref_val(cmp_q[i]), .oe(oe[i]), .lvl(lvl[i]),
      .force_go(frc_go[i]), .force_lvl(frc_lvl[i]),
      .pin(cmp_pin[i]), .match(cmp_hit[i])
    );
  end

  assign cmp1_out = cmp_pin[0];
  assign cmp2_out = cmp_pin[1];

  assign set_v = {wrap, cmp_hit[1], cmp_hit[0], cap_hit[1], cap_hit[0]};
  assign clr_v = wr_stat ? bus_wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_a_q <= '0;
      ctl_b_q <= '0;
      stat_q  <= '0;
      cmp_q   <= '{default: '0};
      irq     <= 1'b0;
    end else begin
      if (wr_a) ctl_a_q <= bus_wdata;
      if (bus_we && bus_addr == A_CTLB) ctl_b_q <= bus_wdata[CB_W-1:0];
      if (bus_we && bus_addr == A_CMP1) cmp_q[0] <= bus_wdata;
      if (bus_we && bus_addr == A_CMP2) cmp_q[1] <= bus_wdata;
      stat_q <= (stat_q & ~clr_v) | set_v;
      irq    <= (ctl_a_q[CA_CAPIE] & (stat_q[ST_CAP1] | stat_q[ST_CAP2]))
              | (ctl_a_q[CA_CMPIE] & (stat_q[ST_CMP1] | stat_q[ST_CMP2]))
              | (ctl_a_q[CA_OVFIE] & stat_q[ST_OVF]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_CTLA:       bus_rdata <= ctl_a_q;
        A_CTLB:       bus_rdata <= REG_W'(ctl_b_q);
        A_STAT:       bus_rdata <= REG_W'(stat_q);
        A_CAP1:       bus_rdata <= cap_val[0];
        A_CAP2:       bus_rdata <= cap_val[1];
        A_CMP1:       bus_rdata <= cmp_q[0];
        A_CMP2:       bus_rdata <= cmp_q[1];
        A_CNT, A_ALT: bus_rdata <= cnt;
        default:      bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cct_checker.sv
module cct_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] ctl_a,
  input logic [4:0] ctl_b,
  input logic [4:0] stat,
  input logic [7:0] cnt,
  input logic [7:0] cap1,
  input logic       irq,
  input logic       pin1,
  input logic       pin2
);
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl_a[7:5] == 3'b000) |=> !irq);

  assert_pin1_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !ctl_b[0] |=> $stable(pin1));

  assert_pin2_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !ctl_b[1] |=> $stable(pin2));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> (cnt == 8'($past(cnt) + 8'd1)));

  assert_wrap_flag_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt) == 8'hFF && cnt == 8'h00) |-> stat[4]);

  assert_cap_flag_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap1) |-> stat[0]);
endmodule

bind cct_timer8 cct_checker u_chk (
  .clk(clk), .rst(rst), .ctl_a(ctl_a_q), .ctl_b(ctl_b_q), .stat(stat_q),
  .cnt(cnt), .cap1(cap_val[0]), .irq(irq), .pin1(cmp1_out), .pin2(cmp2_out)
);

// File: tb/cct_timer8_test.sv
`timescale 1ns/1ps
module cct_timer8_test;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cap1 = 1'b0, cap2 = 1'b0;
  logic       p1, p2, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cct_timer8 #(.PRESCALE(DIV)) uut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .cap1_in(cap1), .cap2_in(cap2),
    .cmp1_out(p1), .cmp2_out(p2), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // move both compare references just behind the counter
  task automatic park();
    logic [7:0] c;
    rd(4'd7, c);
    wr(4'd5, 8'(c - 8'd16));
    wr(4'd6, 8'(c - 8'd16));
  endtask

  task automatic sweep_irq(input logic [7:0] low5, input string tag);
    logic [7:0] s;
    rd(4'd2, s);
    for (int ie = 0; ie < 8; ie++) begin
      logic e;
      wr(4'd0, {3'(ie), low5[4:0]});
      @(negedge clk);
      e = (ie[2] & (s[0] | s[1])) | (ie[1] & (s[2] | s[3])) | (ie[0] & s[4]);
      chk(irq == e, tag, irq, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, c0, c1, s, tgt, tgt2;
    int n;
    idle(4);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(p1 == 0 && p2 == 0, "R1 pins after reset", {p2, p1}, 0);
    chk(irq == 0, "R1 irq after reset", irq, 0);
    for (int a = 0; a < 7; a++) begin
      rd(4'(a), v);
      chk(v == 8'h00, "R1 register reset value", v, 0);
    end

    // R2 counter rate, both count addresses
    rd(4'd7, c0);
    idle(3 * DIV - 2);
    rd(4'd8, c1);
    chk(c1 == 8'(c0 + 8'd3), "R2 count advance over 3 periods", c1, 8'(c0 + 8'd3));

    park();
    wr(4'd2, 8'h1F);

    // R4 capture 1, rising selected
    wr(4'd0, 8'h02);
    rd(4'd7, c0);
    cap1 = 1'b1;
    idle(6);
    rd(4'd7, c1);
    rd(4'd3, v);
    chk(8'(v - c0) <= 8'(c1 - c0), "R4 capture1 value in window", v, c0);
    rd(4'd2, s);
    chk(s[1:0] == 2'b01, "R4 capture1 flag only", s[1:0], 1);

    // R4 unselected falling edge on channel 1
    wr(4'd2, 8'h1F);
    cap1 = 1'b0;
    idle(6);
    rd(4'd2, s);
    chk(s[0] == 1'b0, "R4 falling edge ignored on ch1 flag", s[0], 0);
    rd(4'd3, c0);
    chk(c0 == v, "R4 falling edge ignored on ch1 value", c0, v);

    // R4 capture 2, falling selected (control B bit 4 = 0)
    cap2 = 1'b1;
    idle(6);
    rd(4'd2, s);
    chk(s[1] == 1'b0, "R4 rising edge ignored on ch2", s[1], 0);
    rd(4'd7, c0);
    cap2 = 1'b0;
    idle(6);
    rd(4'd7, c1);
    rd(4'd4, v);
    chk(8'(v - c0) <= 8'(c1 - c0), "R4 capture2 value in window", v, c0);
    rd(4'd2, s);
    chk(s[1] == 1'b1, "R4 capture2 flag", s[1], 1);

    // R8 sweep with only capture flag set
    wr(4'd2, 8'h1F);
    cap1 = 1'b1;
    idle(6);
    sweep_irq(8'h02, "R8 irq sweep capture flag");

    // R3 write-0 keeps, write-1 clears
    rd(4'd2, s);
    chk(s == 8'h01, "R3 status before clear", s, 1);
    wr(4'd2, 8'h00);
    rd(4'd2, s);
    chk(s == 8'h01, "R3 write zero keeps flag", s, 1);
    wr(4'd2, 8'h01);
    rd(4'd2, s);
    chk(s == 8'h00, "R3 write one clears flag", s, 0);

    // R5 compare match with enables
    wr(4'd1, 8'h03);
    wr(4'd0, 8'h05);
    rd(4'd7, c0);
    tgt  = 8'(c0 + 8'd6);
    tgt2 = 8'(c0 + 8'd10);
    wr(4'd5, tgt);
    wr(4'd6, tgt2);
    n = 0;
    while (p1 == 1'b0 && n < 400) begin @(negedge clk); n++; end
    rd(4'd7, v);
    chk(v == tgt, "R5 pin1 set at compare1 count", v, tgt);
    chk(p2 == 1'b0, "R5 pin2 not yet matched", p2, 0);
    n = 0;
    while (p2 == 1'b0 && n < 400) begin @(negedge clk); n++; end
    rd(4'd7, v);
    chk(v == tgt2, "R5 pin2 set at compare2 count", v, tgt2);
    chk(p1 == 1'b1, "R9 pin1 holds after match", p1, 1);
    rd(4'd2, s);
    chk(s[3:2] == 2'b11, "R5 compare flags set", s[3:2], 3);

    // R8 compare enable alone
    wr(4'd0, 8'h45);
    @(negedge clk);
    chk(irq == 1'b1, "R8 compare enable raises irq", irq, 1);
    wr(4'd0, 8'h05);
    @(negedge clk);
    chk(irq == 1'b0, "R8 compare enable off drops irq", irq, 0);

    // R5 match with enable clear: flag only
    wr(4'd2, 8'h1F);
    wr(4'd1, 8'h00);
    wr(4'd0, 8'h00);
    rd(4'd7, c0);
    wr(4'd5, 8'(c0 + 8'd4));
    idle(8 * DIV);
    chk(p1 == 1'b1, "R9 pin1 frozen without enable", p1, 1);
    rd(4'd2, s);
    chk(s[2] == 1'b1, "R5 flag sets without enable", s[2], 1);

    park();

    // R6 force behaviour
    wr(4'd1, 8'h01);
    wr(4'd0, 8'h08);
    chk(p1 == 1'b0, "R6 force1 drives level 0", p1, 0);
    wr(4'd0, 8'h01);
    chk(p1 == 1'b0, "R6 force bit 0 no effect", p1, 0);
    wr(4'd1, 8'h00);
    wr(4'd0, 8'h09);
    chk(p1 == 1'b0, "R6 force with enable clear no effect", p1, 0);
    wr(4'd1, 8'h02);
    wr(4'd0, 8'h10);
    chk(p2 == 1'b0, "R6 force2 drives level 0", p2, 0);
    wr(4'd0, 8'h14);
    chk(p2 == 1'b1, "R6 force2 drives level 1", p2, 1);

    // R7 mode routing for pin 1
    wr(4'd1, 8'h09);
    wr(4'd0, 8'h0C);
    chk(p1 == 1'b1, "R7 PWM mode uses level 2", p1, 1);
    wr(4'd0, 8'h09);
    chk(p1 == 1'b0, "R7 PWM mode ignores level 1", p1, 0);
    wr(4'd1, 8'h05);
    wr(4'd0, 8'h0C);
    chk(p1 == 1'b1, "R7 one-pulse mode uses level 2", p1, 1);
    wr(4'd1, 8'h01);
    wr(4'd0, 8'h0C);
    chk(p1 == 1'b0, "R7 normal mode uses level 1", p1, 0);

    // R2 overflow
    wr(4'd0, 8'h00);
    wr(4'd2, 8'h1F);
    n = 0;
    s = 8'h00;
    while (s[4] == 1'b0 && n < 1500) begin rd(4'd2, s); n++; end
    chk(s[4] == 1'b1, "R2 overflow flag on wrap", s[4], 1);
    park();
    rd(4'd8, v);
    rd(4'd7, v);
    rd(4'd2, s);
    chk(s[4] == 1'b1, "R2 count reads keep overflow", s[4], 1);
    wr(4'd2, 8'h0F);
    rd(4'd2, s);
    chk(s == 8'h10, "R3 write zero keeps overflow", s, 8'h10);
    sweep_irq(8'h00, "R8 irq sweep overflow flag");
    wr(4'd2, 8'h10);
    rd(4'd2, s);
    chk(s[4] == 1'b0, "R3 write one clears overflow", s[4], 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule